// File: doc/BRIEF.md
# Masked Vector Carry-less Multiplier

This block executes element-wise carry-less multiplication (polynomial multiplication over GF(2)) on a vector of 64-bit elements. It takes a full 32-bit vector instruction word, decodes from it the result selection (lower or upper 64 bits of the 128-bit product) and the operand form (vector-vector, or vector-scalar with one 64-bit scalar broadcast to every element), and steps through the element range one element per cycle.

The surrounding pipeline presents the source vectors, the old destination vector, the mask register contents, the element width code and the start and length indices together with a one-cycle `start` strobe. The block latches everything at acceptance. It then writes a fresh product into each element that lies inside the range and is enabled by the mask, and leaves every other element at its old destination value. A one-cycle `done` pulse marks completion. At that point `vdNew` holds the vector to write back and `vstartOut` has returned to zero. The register indices decoded from the word are given out so that the register file can fetch operands and address the write-back.

Top module: `vclmul_unit`

## Requirements
- R1: After reset `busy`, `done` and `illegal` are 0, and `vdNew` and `vstartOut` are all zeros.
- R2: When funct6 (bits 31:26) is 0b001100, each computed element is the lower 64 bits of the carry-less product of the vs2 element and the second operand.
- R3: When funct6 is 0b001101, each computed element is the upper 64 bits of that product: the XOR, over every set bit i of the second operand with i ≥ 1, of the vs2 element shifted right by 64 − i.
- R4: When funct3 (bits 14:12) is 0b010, the second operand is the vs1 element of the same index. When funct3 is 0b110, it is `scalarOp` for every element. The first operand is always the vs2 element.
- R5: The operation is legal only when bits 6:0 equal 0b1010111, funct6 is one of the two codes above and funct3 is one of the two codes above. `srcVs2Idx`, `srcVs1Idx` and `dstIdx` show bits 24:20, 19:15 and 11:7 of `instr`. An illegal operation pulses `done` with `illegal` = 1 one cycle after acceptance, leaves `vdNew` equal to `vdOld` and leaves `vstartOut` equal to `vstartIn`.
- R6: The element width code `sewCode` must be 3'b011 (64-bit). Any other code makes the operation illegal, with the handling of R5.
- R7: When bit 25 (vm) is 1, every element in range is written. When vm is 0, element e is written only if `maskBits[e]` is 1, and a masked-off element keeps its `vdOld` value.
- R8: Only elements with vstart ≤ e < min(vl, NUM_ELEM) are computed. All other elements keep their `vdOld` value. When vstart ≥ vl, the result equals `vdOld`.
- R9: When a legal operation completes, `vstartOut` is 0 in the cycle in which `done` is 1.
- R10: `busy` is 1 from the cycle after acceptance until completion. `done` is a single-cycle pulse. For a legal operation it appears n + 1 clock edges after the accepting edge, where n = max(0, min(vl, NUM_ELEM) − vstart).
- R11: A `start` pulse while `busy` is 1 is ignored, and the running operation's result is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Accept request, sampled when not busy |
| instr | input | 32 | Vector instruction word |
| sewCode | input | 3 | Element width code, 3'b011 = 64-bit |
| scalarOp | input | 64 | Scalar second operand for the vector-scalar form |
| vs1Data | input | NUM_ELEM*64 | Second source vector, element e in bits e*64 +: 64 |
| vs2Data | input | NUM_ELEM*64 | First source vector |
| vdOld | input | NUM_ELEM*64 | Prior destination vector |
| maskBits | input | NUM_ELEM | Mask register contents, one bit per element |
| vstartIn | input | IDX_W | First element index |
| vlIn | input | IDX_W | Element count bound (exclusive end index) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Last accepted operation was illegal, valid with done |
| vdNew | output | NUM_ELEM*64 | Vector to write back |
| vstartOut | output | IDX_W | Start index, cleared on legal completion |
| srcVs1Idx | output | 5 | Decoded vs1/rs1 register index |
| srcVs2Idx | output | 5 | Decoded vs2 register index |
| dstIdx | output | 5 | Decoded destination register index |

## Verification
The bench aims at the upper-half path with single-bit and all-ones operands. A design that shifted by the wrong amount, or that kept the i = 0 term, would return a corrupted high word, for example a nonzero value where only bit 126 of the product is set. An all-zero mask, vstart equal to vl and vl beyond the element count are run to expose a loop that overruns its window, writes masked elements or drops the old destination value. Wrong opcode, funct6, funct3 and element width values are used to catch a decoder that is too permissive, and a start strobe during a run checks that a second operation cannot corrupt the first.

// File: rtl/vclmul_pkg.sv
package vclmul_pkg;
  localparam int ELEM_W = 64;

  localparam logic [6:0] OPC_VECTOR = 7'b1010111;
  localparam logic [5:0] F6_LOW     = 6'b001100;
  localparam logic [5:0] F6_HIGH    = 6'b001101;
  localparam logic [2:0] F3_VECVEC  = 3'b010;
  localparam logic [2:0] F3_VECSCA  = 3'b110;
  localparam logic [2:0] SEW_64     = 3'b011;

  typedef struct packed {
    logic legal;
    logic highHalf;
    logic scalarForm;
    logic unmasked;
  } opDec_t;

  typedef struct packed {
    logic load;
    logic write;
  } strobe_t;

  function automatic opDec_t decodeOp(input logic [31:0] word, input logic [2:0] sew);
    opDec_t d;
    logic f6Ok;
    logic f3Ok;
    f6Ok         = (word[31:26] == F6_LOW) || (word[31:26] == F6_HIGH);
    f3Ok         = (word[14:12] == F3_VECVEC) || (word[14:12] == F3_VECSCA);
    d.legal      = f6Ok && f3Ok && (word[6:0] == OPC_VECTOR) && (sew == SEW_64);
    d.highHalf   = word[26];
    d.scalarForm = word[14];
    d.unmasked   = word[25];
    return d;
  endfunction
endpackage

// File: rtl/vclmul_core.sv
module vclmul_core #(
  parameter int W = 64
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] prodLo,
  output logic [W-1:0] prodHi
);
  localparam int PW = 2 * W;

  logic [PW-1:0] partial [W];
  logic [PW-1:0] accum;

  for (genvar gi = 0; gi < W; gi++) begin : g_part
    assign partial[gi] = opB[gi] ? ({{W{1'b0}}, opA} << gi) : '0;
  end

  always_comb begin
    accum = '0;
    for (int i = 0; i < W; i++) begin
      accum = accum ^ partial[i];
    end
  end

  assign prodLo = accum[W-1:0];
  assign prodHi = accum[PW-1:W];
endmodule

// File: rtl/vclmul_datapath.sv
module vclmul_datapath
  import vclmul_pkg::*;
#(
  parameter int NUM_ELEM = 4,
  parameter int SEL_W    = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    strb,
  input  logic [SEL_W-1:0]           elemSel,
  input  logic                       highIn,
  input  logic                       scalarFormIn,
  input  logic                       unmaskedIn,
  input  logic [ELEM_W-1:0]          scalarIn,
  input  logic [NUM_ELEM*ELEM_W-1:0] vs1In,
  input  logic [NUM_ELEM*ELEM_W-1:0] vs2In,
  input  logic [NUM_ELEM*ELEM_W-1:0] vdOldIn,
  input  logic [NUM_ELEM-1:0]        maskIn,
  output logic [NUM_ELEM*ELEM_W-1:0] resultVec
);
  logic [ELEM_W-1:0]   vs1Reg [NUM_ELEM];
  logic [ELEM_W-1:0]   vs2Reg [NUM_ELEM];
  logic [ELEM_W-1:0]   resArr [NUM_ELEM];
  logic [ELEM_W-1:0]   scalarReg;
  logic [NUM_ELEM-1:0] maskReg;
  logic                highReg;
  logic                scalarFormReg;

  logic [ELEM_W-1:0] opA;
  logic [ELEM_W-1:0] opB;
  logic [ELEM_W-1:0] prodLo;
  logic [ELEM_W-1:0] prodHi;
  logic [ELEM_W-1:0] elemResult;
  logic              elemEnable;

  assign opA        = vs2Reg[elemSel];
  assign opB        = scalarFormReg ? scalarReg : vs1Reg[elemSel];
  assign elemResult = highReg ? prodHi : prodLo;
  assign elemEnable = strb.write && maskReg[elemSel];

  vclmul_core #(.W(ELEM_W)) u_core (
    .opA   (opA),
    .opB   (opB),
    .prodLo(prodLo),
    .prodHi(prodHi)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < NUM_ELEM; e++) begin
        vs1Reg[e] <= '0;
        vs2Reg[e] <= '0;
        resArr[e] <= '0;
      end
      scalarReg     <= '0;
      maskReg       <= '0;
      highReg       <= 1'b0;
      scalarFormReg <= 1'b0;
    end else if (strb.load) begin
      for (int e = 0; e < NUM_ELEM; e++) begin
        vs1Reg[e] <= vs1In[e*ELEM_W +: ELEM_W];
        vs2Reg[e] <= vs2In[e*ELEM_W +: ELEM_W];
        resArr[e] <= vdOldIn[e*ELEM_W +: ELEM_W];
      end
      scalarReg     <= scalarIn;
      maskReg       <= unmaskedIn ? '1 : maskIn;
      highReg       <= highIn;
      scalarFormReg <= scalarFormIn;
    end else if (elemEnable) begin
      resArr[elemSel] <= elemResult;
    end
  end

  for (genvar ge = 0; ge < NUM_ELEM; ge++) begin : g_out
    assign resultVec[ge*ELEM_W +: ELEM_W] = resArr[ge];
  end

  AST_MASKED_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.write && !strb.load && !maskReg[elemSel]) |=> $stable(resultVec)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.write && !strb.load) |=> $stable(resultVec)); // R8
endmodule

// File: rtl/vclmul_ctrl.sv
module vclmul_ctrl
  import vclmul_pkg::*;
#(
  parameter int NUM_ELEM = 4,
  parameter int IDX_W    = 3,
  parameter int SEL_W    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             legalIn,
  input  logic [IDX_W-1:0] vstartIn,
  input  logic [IDX_W-1:0] vlIn,
  output strobe_t          strb,
  output logic [SEL_W-1:0] elemSel,
  output logic             busy,
  output logic             done,
  output logic             illegal,
  output logic [IDX_W-1:0] vstartOut
);
  typedef enum logic {ST_IDLE, ST_RUN} state_t;

  localparam logic [IDX_W-1:0] ELEM_LIMIT = IDX_W'(NUM_ELEM);

  state_t           state;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] vlReg;
  logic [IDX_W-1:0] vstartReg;
  logic [IDX_W-1:0] vlClamp;
  logic             doneReg;
  logic             illegalReg;
  logic             inRange;

  assign vlClamp    = (vlIn > ELEM_LIMIT) ? ELEM_LIMIT : vlIn;
  assign inRange    = idx < vlReg;
  assign strb.load  = (state == ST_IDLE) && start;
  assign strb.write = (state == ST_RUN) && inRange;
  assign elemSel    = idx[SEL_W-1:0];
  assign busy       = (state == ST_RUN);
  assign done       = doneReg;
  assign illegal    = illegalReg;
  assign vstartOut  = vstartReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      idx        <= '0;
      vlReg      <= '0;
      vstartReg  <= '0;
      doneReg    <= 1'b0;
      illegalReg <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            illegalReg <= !legalIn;
            vstartReg  <= vstartIn;
            if (legalIn) begin
              state <= ST_RUN;
              idx   <= vstartIn;
              vlReg <= vlClamp;
            end else begin
              doneReg <= 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (inRange) begin
            idx <= idx + 1'b1;
          end else begin
            state     <= ST_IDLE;
            doneReg   <= 1'b1;
            vstartReg <= '0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10

  AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strb.load); // R11

  AST_VSTART_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (done && !illegal) |-> (vstartOut == '0)); // R9

  AST_WRITE_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.write |-> (idx >= vstartReg && idx < ELEM_LIMIT)); // R8

  AST_ILLEGAL_SKIP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !legalIn) |=> (done && illegal && !busy)); // R5
endmodule

// File: rtl/vclmul_unit.sv
module vclmul_unit
  import vclmul_pkg::*;
#(
  parameter int NUM_ELEM = 4,
  localparam int IDX_W   = $clog2(NUM_ELEM + 1),
  localparam int SEL_W   = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1,
  localparam int VEC_W   = NUM_ELEM * ELEM_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [31:0]         instr,
  input  logic [2:0]          sewCode,
  input  logic [ELEM_W-1:0]   scalarOp,
  input  logic [VEC_W-1:0]    vs1Data,
  input  logic [VEC_W-1:0]    vs2Data,
  input  logic [VEC_W-1:0]    vdOld,
  input  logic [NUM_ELEM-1:0] maskBits,
  input  logic [IDX_W-1:0]    vstartIn,
  input  logic [IDX_W-1:0]    vlIn,
  output logic                busy,
  output logic                done,
  output logic                illegal,
  output logic [VEC_W-1:0]    vdNew,
  output logic [IDX_W-1:0]    vstartOut,
  output logic [4:0]          srcVs1Idx,
  output logic [4:0]          srcVs2Idx,
  output logic [4:0]          dstIdx
);
  opDec_t           dec;
  strobe_t          strb;
  logic [SEL_W-1:0] elemSel;

  assign dec       = decodeOp(instr, sewCode);
  assign srcVs2Idx = instr[24:20];
  assign srcVs1Idx = instr[19:15];
  assign dstIdx    = instr[11:7];

  vclmul_ctrl #(.NUM_ELEM(NUM_ELEM), .IDX_W(IDX_W), .SEL_W(SEL_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .legalIn  (dec.legal),
    .vstartIn (vstartIn),
    .vlIn     (vlIn),
    .strb     (strb),
    .elemSel  (elemSel),
    .busy     (busy),
    .done     (done),
    .illegal  (illegal),
    .vstartOut(vstartOut)
  );

  vclmul_datapath #(.NUM_ELEM(NUM_ELEM), .SEL_W(SEL_W)) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .elemSel     (elemSel),
    .highIn      (dec.highHalf),
    .scalarFormIn(dec.scalarForm),
    .unmaskedIn  (dec.unmasked),
    .scalarIn    (scalarOp),
    .vs1In       (vs1Data),
    .vs2In       (vs2Data),
    .vdOldIn     (vdOld),
    .maskIn      (maskBits),
    .resultVec   (vdNew)
  );
endmodule

// File: tb/vclmul_unit_tb.sv
`timescale 1ns/1ps
module vclmul_unit_tb;
  localparam int NE = 4;
  localparam int IW = 3;
  localparam int VW = NE * 64;

  typedef struct packed {
    logic [5:0] f6;
    logic       vm;
    logic [2:0] f3;
    logic [6:0] opc;
    logic [2:0] sew;
    logic [3:0] mask;
    logic [2:0] vs;
    logic [2:0] vl;
    logic [1:0] pat;
  } vec_t;

  localparam logic [6:0] OPC = 7'b1010111;
  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{6'b001100, 1'b1, 3'b010, OPC, 3'b011, 4'h0, 3'd0, 3'd4, 2'd0}, // R2 vv low
    '{6'b001101, 1'b1, 3'b010, OPC, 3'b011, 4'h0, 3'd0, 3'd4, 2'd0}, // R3 vv high
    '{6'b001101, 1'b1, 3'b110, OPC, 3'b011, 4'h0, 3'd0, 3'd4, 2'd0}, // R4 vx high
    '{6'b001100, 1'b1, 3'b110, OPC, 3'b011, 4'h0, 3'd0, 3'd4, 2'd0}, // R4 vx low
    '{6'b001101, 1'b1, 3'b010, OPC, 3'b011, 4'h0, 3'd0, 3'd4, 2'd1}, // R3 all ones
    '{6'b001100, 1'b1, 3'b010, OPC, 3'b011, 4'h0, 3'd0, 3'd4, 2'd1}, // R2 all ones
    '{6'b001101, 1'b1, 3'b010, OPC, 3'b011, 4'h0, 3'd0, 3'd4, 2'd2}, // R3 single bit
    '{6'b001101, 1'b0, 3'b010, OPC, 3'b011, 4'h5, 3'd0, 3'd4, 2'd0}, // R7 partial mask
    '{6'b001100, 1'b0, 3'b110, OPC, 3'b011, 4'h0, 3'd0, 3'd4, 2'd0}, // R7 zero mask
    '{6'b001101, 1'b1, 3'b010, OPC, 3'b011, 4'h0, 3'd1, 3'd3, 2'd0}, // R8 window
    '{6'b001101, 1'b1, 3'b010, OPC, 3'b011, 4'h0, 3'd2, 3'd2, 2'd0}, // R8 vstart==vl
    '{6'b001100, 1'b1, 3'b010, OPC, 3'b011, 4'h0, 3'd0, 3'd7, 2'd0}, // R8 vl clamp
    '{6'b001101, 1'b1, 3'b010, 7'b0110011, 3'b011, 4'h0, 3'd1, 3'd4, 2'd0}, // R5 opcode
    '{6'b001110, 1'b1, 3'b010, OPC, 3'b011, 4'h0, 3'd1, 3'd4, 2'd0}, // R5 funct6
    '{6'b001101, 1'b1, 3'b000, OPC, 3'b011, 4'h0, 3'd1, 3'd4, 2'd0}, // R5 funct3
    '{6'b001101, 1'b1, 3'b010, OPC, 3'b010, 4'h0, 3'd1, 3'd4, 2'd0}, // R6 width
    '{6'b001101, 1'b0, 3'b010, OPC, 3'b011, 4'hA, 3'd1, 3'd4, 2'd3}  // R7 zero operands
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [31:0]   instr = '0;
  logic [2:0]    sewCode = 3'b011;
  logic [63:0]   scalarOp = '0;
  logic [VW-1:0] vs1Data = '0;
  logic [VW-1:0] vs2Data = '0;
  logic [VW-1:0] vdOld = '0;
  logic [NE-1:0] maskBits = '0;
  logic [IW-1:0] vstartIn = '0;
  logic [IW-1:0] vlIn = '0;
  logic          busy;
  logic          done;
  logic          illegal;
  logic [VW-1:0] vdNew;
  logic [IW-1:0] vstartOut;
  logic [4:0]    srcVs1Idx;
  logic [4:0]    srcVs2Idx;
  logic [4:0]    dstIdx;

  int checkCnt = 0;
  int failCnt  = 0;
  int cycleCnt = 0;

  vclmul_unit #(.NUM_ELEM(NE)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .instr(instr), .sewCode(sewCode),
    .scalarOp(scalarOp), .vs1Data(vs1Data), .vs2Data(vs2Data), .vdOld(vdOld),
    .maskBits(maskBits), .vstartIn(vstartIn), .vlIn(vlIn), .busy(busy),
    .done(done), .illegal(illegal), .vdNew(vdNew), .vstartOut(vstartOut),
    .srcVs1Idx(srcVs1Idx), .srcVs2Idx(srcVs2Idx), .dstIdx(dstIdx)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycleCnt <= cycleCnt + 1;
    if (cycleCnt > 20000) begin
      failCnt = failCnt + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer than 20000", cycleCnt);
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checkCnt = checkCnt + 1;
    if (!ok) begin
      failCnt = failCnt + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] refClmul(input logic [63:0] a, input logic [63:0] b);
    logic [127:0] p = '0;
    for (int i = 0; i < 64; i++) if (b[i]) p = p ^ ({64'd0, a} << i);
    return p;
  endfunction

  function automatic logic [63:0] mix(input int seed);
    logic [63:0] h;
    h = 64'(seed + 1) * 64'h9E3779B97F4A7C15;
    h = h ^ (h >> 29);
    h = h * 64'hBF58476D1CE4E5B9;
    h = h ^ (h >> 32);
    return h;
  endfunction

  // which: 0 = vs1, 1 = vs2, 2 = old destination, 3 = scalar
  function automatic logic [63:0] opnd(input int pat, input int which, input int elem, input int k);
    if (which == 2) return mix(k * 64 + which * 8 + elem);
    case (pat)
      0: return mix(k * 64 + which * 8 + elem);
      1: return '1;
      2: return (which == 0) ? (64'd1 << (63 - elem * 5)) :
                (which == 1) ? (64'd1 << ((elem * 21 + 3) % 64)) : (64'd1 << 40);
      default: return '0;
    endcase
  endfunction

  function automatic logic [31:0] mkInstr(input vec_t v);
    return {v.f6, v.vm, 5'd9, 5'd17, v.f3, 5'd4, v.opc};
  endfunction

  function automatic bit isLegal(input vec_t v);
    return (v.opc == OPC) && (v.f6 == 6'b001100 || v.f6 == 6'b001101) &&
           (v.f3 == 3'b010 || v.f3 == 3'b110) && (v.sew == 3'b011);
  endfunction

  function automatic int elemCount(input vec_t v);
    int vlE = (v.vl > NE) ? NE : int'(v.vl);
    return (vlE > int'(v.vs)) ? vlE - int'(v.vs) : 0;
  endfunction

  function automatic logic [VW-1:0] expVec(input vec_t v, input logic [VW-1:0] a1,
      input logic [VW-1:0] a2, input logic [VW-1:0] d, input logic [63:0] sc);
    logic [VW-1:0] r = d;
    logic [127:0] p;
    logic [63:0] b;
    int vlE = (v.vl > NE) ? NE : int'(v.vl);
    if (!isLegal(v)) return d;
    for (int e = 0; e < NE; e++) begin
      if (e >= int'(v.vs) && e < vlE && (v.vm || v.mask[e])) begin
        b = (v.f3 == 3'b110) ? sc : a1[e*64 +: 64];
        p = refClmul(a2[e*64 +: 64], b);
        r[e*64 +: 64] = (v.f6 == 6'b001101) ? p[127:64] : p[63:0];
      end
    end
    return r;
  endfunction

  task automatic loadInputs(input vec_t v, input int k);
    instr    = mkInstr(v);
    sewCode  = v.sew;
    maskBits = v.mask;
    vstartIn = v.vs;
    vlIn     = v.vl;
    scalarOp = opnd(v.pat, 3, 0, k);
    for (int e = 0; e < NE; e++) begin
      vs1Data[e*64 +: 64] = opnd(v.pat, 0, e, k);
      vs2Data[e*64 +: 64] = opnd(v.pat, 1, e, k);
      vdOld[e*64 +: 64]   = opnd(v.pat, 2, e, k);
    end
  endtask

  // Drives start at a negedge and returns the negedge count until done.
  task automatic pulseAndWait(output int lat);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 50) begin
      @(negedge clk);
      lat = lat + 1;
    end
  endtask

  task automatic runVec(input int k);
    vec_t v = VECS[k];
    logic [VW-1:0] exp;
    int lat;
    int expLat;
    string tag;
    @(negedge clk);
    loadInputs(v, k);
    exp = expVec(v, vs1Data, vs2Data, vdOld, scalarOp);
    expLat = isLegal(v) ? elemCount(v) + 2 : 1;
    tag = isLegal(v) ? "R10" : "R5";
    pulseAndWait(lat);
    chk(lat == expLat, $sformatf("%s latency vec %0d", tag, k), VW'(lat), VW'(expLat));
    chk(vdNew == exp, $sformatf("R2/R3/R4/R7/R8 result vec %0d", k), vdNew, exp);
    chk(illegal == !isLegal(v), $sformatf("R5/R6 illegal flag vec %0d", k), VW'(illegal), VW'(!isLegal(v)));
    if (isLegal(v))
      chk(vstartOut == '0, $sformatf("R9 vstart cleared vec %0d", k), VW'(vstartOut), '0);
    else
      chk(vstartOut == v.vs, $sformatf("R5 vstart kept vec %0d", k), VW'(vstartOut), VW'(v.vs));
    @(negedge clk);
    chk(!done, $sformatf("R10 done single pulse vec %0d", k), VW'(done), '0);
  endtask

  initial begin
    vec_t bv;
    logic [VW-1:0] exp;
    logic [VW-1:0] expHi;
    int lat;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!busy && !done && !illegal, "R1 reset flags", VW'({busy, done, illegal}), '0);
    chk(vdNew == '0, "R1 reset vdNew", vdNew, '0);
    chk(vstartOut == '0, "R1 reset vstartOut", VW'(vstartOut), '0);
    rstN = 1'b1;

    for (int k = 0; k < NV; k++) runVec(k);

    // R5 register index fields
    @(negedge clk);
    instr = {6'b001101, 1'b1, 5'd21, 5'd6, 3'b010, 5'd30, OPC};
    #1;
    chk(srcVs2Idx == 5'd21 && srcVs1Idx == 5'd6 && dstIdx == 5'd30, "R5 field decode",
        VW'({srcVs2Idx, srcVs1Idx, dstIdx}), VW'({5'd21, 5'd6, 5'd30}));

    // R3 R2 literal: bit 63 times bit 63 gives product bit 126
    bv = VECS[1];
    loadInputs(bv, 0);
    vs1Data = '0; vs2Data = '0;
    vs1Data[63] = 1'b1; vs2Data[63] = 1'b1;
    vs1Data[64] = 1'b1; vs2Data[64] = 1'b1;
    expHi = vdOld;
    expHi[63:0]    = 64'h4000_0000_0000_0000;
    expHi[127:64]  = 64'h0;
    expHi[191:128] = 64'h0;
    expHi[255:192] = 64'h0;
    pulseAndWait(lat);
    chk(vdNew == expHi, "R3 literal high half", vdNew, expHi);
    @(negedge clk);
    bv = VECS[0];
    instr = mkInstr(bv);
    exp = '0;
    exp[64] = 1'b1;
    pulseAndWait(lat);
    chk(vdNew == exp, "R2 literal low half", vdNew, exp);

    // R11 start while busy is ignored; R10 busy during run
    @(negedge clk);
    bv = VECS[1];
    loadInputs(bv, 40);
    exp = expVec(bv, vs1Data, vs2Data, vdOld, scalarOp);
    start = 1'b1;
    @(negedge clk);
    chk(busy, "R10 busy after accept", VW'(busy), VW'(1));
    instr = mkInstr(VECS[0]);
    vdOld = '1;
    vs2Data = '1;
    @(negedge clk);
    start = 1'b0;
    lat = 2;
    while (!done && lat < 50) begin
      @(negedge clk);
      lat = lat + 1;
    end
    chk(vdNew == exp, "R11 start during busy ignored", vdNew, exp);
    chk(lat == 6, "R11 latency unchanged", VW'(lat), VW'(6));
    @(negedge clk);
    chk(!busy && !done, "R10 idle after completion", VW'({busy, done}), '0);

    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule